// File: doc/BRIEF.md
# I2C Repeated-Start Sequencer

This block drives a repeated-start condition onto an open-drain I2C line pair. Software sets a request bit in a small control register. Once the byte engine reports that it is idle, the sequencer takes the pins through four timed phases:

1. SCL held low with SDA released.
2. SCL released.
3. Both lines high.
4. SDA pulled low while SCL stays high.

A reload-and-count baud generator times each phase. The generator restarts only after the sequencer has sampled the pin at the level it just asked for. This lets a slow or stretching bus lengthen a phase without breaking the timing of the phases that follow.

While the sequence runs, the block guards its registers. A write to the data buffer is refused and raises a write-collision flag. Writes to the control bits are dropped. The sequencer also watches for another master on the bus. A bus collision releases both lines, returns the sequencer to idle and clears the request.

After a normal finish, SDA stays held low so that a byte transfer can follow. An interrupt flag marks the end of the sequence, and a start-detected flag reports the start condition seen on the pins.

Top module: `rs_restart`

## Requirements
- R1: Control bit 0 is the request bit. A control write made while `busy` is high leaves the request bit at 0, and no sequence starts.
- R2: A control write with bit 0 set while idle makes `ctl_q[0]` read 1 on the next cycle. `scl_oe` rises one cycle after that, with `sda_oe` at 0.
- R3: After SCL is sampled low, SCL stays driven for reload+1 cycles, so `scl_oe` is high for reload+2 cycles in all. SCL is released only at a timeout where SDA is sampled high; while SDA is held low, `scl_oe` stays high.
- R4: From the release of SCL, both lines stay undriven for reload+2 cycles (one cycle to sample SCL high, then reload+1 counted cycles). SDA is then driven low. `sda_oe` and `scl_oe` are never high together.
- R5: SDA is driven low for reload+1 cycles. Then `irq` sets and the request bit clears on the same edge, and `sda_oe` stays high afterwards while idle.
- R6: `start_det` sets one cycle after SDA is sampled going low while SCL was, and still is, sampled high.
- R7: A buffer write while the sequence runs (request bit set or sequencer not idle) leaves `buf_q` unchanged and sets `wcol`. A buffer write while idle loads `buf_q` on the next cycle.
- R8: Control writes while the sequence runs leave bits 4..1 unchanged. Writes while idle load them on the next cycle.
- R9: If SDA is sampled low when SCL is first sampled high after its release, `bcol` sets.
- R10: If SCL is sampled low during the both-high phase, before SDA is asserted, `bcol` sets.
- R11: On a bus collision, `sda_oe` and `scl_oe` both read 0 and the request bit reads 0 on the same cycle as `bcol`.
- R12: After reset all outputs read 0. The flags `start_det`, `irq`, `wcol` and `bcol` are sticky, and they clear when the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy | input | 1 | Byte engine busy; blocks request acceptance |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Control write data; bit 0 is the request |
| ctl_q | output | 5 | Control register contents |
| buf_wr | input | 1 | Data buffer write strobe |
| buf_wdata | input | 8 | Data buffer write data |
| buf_q | output | 8 | Data buffer contents |
| reload | input | 7 | Baud generator reload value |
| sda_in | input | 1 | Sampled SDA level |
| scl_in | input | 1 | Sampled SCL level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| scl_oe | output | 1 | Pull SCL low when 1 |
| start_det | output | 1 | Start condition seen on the pins |
| irq | output | 1 | Sequence finished |
| wcol | output | 1 | Buffer write refused |
| bcol | output | 1 | Bus collision |

## Verification
With the lines wired straight back, the phase lengths fall due at fixed offsets:

- `scl_oe` rises two cycles after the request write and stays high for reload+2 cycles.
- `sda_oe` rises reload+2 cycles after SCL is released.
- `start_det` follows one cycle later.
- `irq` lands reload+1 cycles after `sda_oe` rises.

The bench samples on falling edges and counts falling edges between port transitions, so each measured length is compared with the value the bench derives for that reload. Register guards are due on the cycle after the write strobe. Collisions are forced on the falling edge inside the target phase, and the flag and the line release are checked on the next falling edge.

// File: rtl/rs_pkg.sv
package rs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SCL_DN  = 3'd1,
    ST_SDA_UP  = 3'd2,
    ST_SCL_UP  = 3'd3,
    ST_BOTH_HI = 3'd4,
    ST_SDA_DN  = 3'd5
  } rs_state_e;

  localparam int FL_START = 0;
  localparam int FL_IRQ   = 1;
  localparam int FL_WCOL  = 2;
  localparam int FL_BCOL  = 3;
  localparam int NFLAG    = 4;

endpackage

// File: rtl/rs_baud.sv
module rs_baud #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          run,
  input  logic [CW-1:0] reload,
  output logic          tmo
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load) begin
      cnt_d  = reload;
      cnt_en = 1'b1;
    end else if (run && (cnt_q != '0)) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign tmo = (cnt_q == '0);

endmodule

// File: rtl/rs_pins.sv
module rs_pins (
  input  logic clk,
  input  logic rst_n,
  input  logic sda_in,
  input  logic scl_in,
  output logic start_seen
);

  logic sda_prev, scl_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_prev <= 1'b1;
      scl_prev <= 1'b1;
    end else begin
      sda_prev <= sda_in;
      scl_prev <= scl_in;
    end
  end

  assign start_seen = scl_in && scl_prev && sda_prev && !sda_in;

endmodule

// File: rtl/rs_fsm.sv
module rs_fsm
  import rs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req,
  input  logic      busy,
  input  logic      sda_in,
  input  logic      scl_in,
  input  logic      tmo,
  output rs_state_e state,
  output logic      sda_drv,
  output logic      scl_drv,
  output logic      cnt_load,
  output logic      cnt_run,
  output logic      accept,
  output logic      done,
  output logic      coll
);

  rs_state_e state_q, state_d;
  logic      hold_q, hold_d;

  always_comb begin
    state_d  = state_q;
    hold_d   = hold_q;
    sda_drv  = 1'b0;
    scl_drv  = 1'b0;
    cnt_load = 1'b0;
    cnt_run  = 1'b0;
    accept   = 1'b0;
    done     = 1'b0;
    coll     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        sda_drv = hold_q;
        if (req && !busy) begin
          accept  = 1'b1;
          hold_d  = 1'b0;
          state_d = ST_SCL_DN;
        end
      end
      ST_SCL_DN: begin
        scl_drv = 1'b1;
        if (!scl_in) begin
          cnt_load = 1'b1;
          state_d  = ST_SDA_UP;
        end
      end
      ST_SDA_UP: begin
        scl_drv = 1'b1;
        cnt_run = 1'b1;
        if (tmo && sda_in) state_d = ST_SCL_UP;
      end
      ST_SCL_UP: begin
        if (scl_in) begin
          if (!sda_in) begin
            coll    = 1'b1;
            state_d = ST_IDLE;
          end else begin
            cnt_load = 1'b1;
            state_d  = ST_BOTH_HI;
          end
        end
      end
      ST_BOTH_HI: begin
        cnt_run = 1'b1;
        if (!scl_in) begin
          coll    = 1'b1;
          state_d = ST_IDLE;
        end else if (tmo) begin
          cnt_load = 1'b1;
          state_d  = ST_SDA_DN;
        end
      end
      ST_SDA_DN: begin
        sda_drv = 1'b1;
        cnt_run = 1'b1;
        if (tmo) begin
          done    = 1'b1;
          hold_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hold_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      hold_q  <= hold_d;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/rs_restart.sv
module rs_restart
  import rs_pkg::*;
#(
  parameter int CW   = 7,
  parameter int BW   = 8,
  parameter int CTLW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            busy,
  input  logic            ctl_wr,
  input  logic [CTLW-1:0] ctl_wdata,
  output logic [CTLW-1:0] ctl_q,
  input  logic            buf_wr,
  input  logic [BW-1:0]   buf_wdata,
  output logic [BW-1:0]   buf_q,
  input  logic [CW-1:0]   reload,
  input  logic            sda_in,
  input  logic            scl_in,
  output logic            sda_oe,
  output logic            scl_oe,
  output logic            start_det,
  output logic            irq,
  output logic            wcol,
  output logic            bcol
);

  localparam int REQ = 0;

  logic [1:0]       rst_pipe;
  logic             rst_n_s;
  rs_state_e        state;
  logic             tmo, cnt_load, cnt_run;
  logic             accept, done, coll, start_seen;
  logic             seq_active;
  logic [CTLW-1:0]  ctl_d;
  logic             ctl_en;
  logic [BW-1:0]    buf_d;
  logic             buf_en;
  logic [NFLAG-1:0] f_set, f_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  rs_baud #(.CW(CW)) u_baud (
    .clk(clk), .rst_n(rst_n_s), .load(cnt_load), .run(cnt_run),
    .reload(reload), .tmo(tmo)
  );

  rs_pins u_pins (
    .clk(clk), .rst_n(rst_n_s), .sda_in(sda_in), .scl_in(scl_in),
    .start_seen(start_seen)
  );

  rs_fsm u_fsm (
    .clk(clk), .rst_n(rst_n_s), .req(ctl_q[REQ]), .busy(busy),
    .sda_in(sda_in), .scl_in(scl_in), .tmo(tmo), .state(state),
    .sda_drv(sda_oe), .scl_drv(scl_oe), .cnt_load(cnt_load),
    .cnt_run(cnt_run), .accept(accept), .done(done), .coll(coll)
  );

  assign seq_active = ctl_q[REQ] || (state != ST_IDLE);

  always_comb begin
    ctl_d  = ctl_q;
    ctl_en = 1'b0;
    if (ctl_wr && !seq_active) begin
      ctl_d      = ctl_wdata;
      ctl_d[REQ] = ctl_wdata[REQ] && !busy;
      ctl_en     = 1'b1;
    end else if (done || coll) begin
      ctl_d[REQ] = 1'b0;
      ctl_en     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    ctl_q <= '0;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  always_comb begin
    buf_d  = buf_wdata;
    buf_en = buf_wr && !seq_active;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    buf_q <= '0;
    else if (buf_en) buf_q <= buf_d;
  end

  always_comb begin
    f_set           = '0;
    f_set[FL_START] = start_seen;
    f_set[FL_IRQ]   = done;
    f_set[FL_WCOL]  = buf_wr && seq_active;
    f_set[FL_BCOL]  = coll;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n_s) begin
      if (!rst_n_s)      f_q[i] <= 1'b0;
      else if (f_set[i]) f_q[i] <= 1'b1;
      else if (accept)   f_q[i] <= 1'b0;
    end
  end

  assign start_det = f_q[FL_START];
  assign irq       = f_q[FL_IRQ];
  assign wcol      = f_q[FL_WCOL];
  assign bcol      = f_q[FL_BCOL];

endmodule

// File: rtl/rs_restart_chk.sv
module rs_restart_chk #(
  parameter int BW   = 8,
  parameter int CTLW = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            ctl_wr,
  input logic [CTLW-1:0] ctl_wdata,
  input logic [CTLW-1:0] ctl_q,
  input logic            buf_wr,
  input logic [BW-1:0]   buf_q,
  input logic            sda_in,
  input logic            scl_in,
  input logic            sda_oe,
  input logic            scl_oe,
  input logic            start_det,
  input logic            irq,
  input logic            wcol,
  input logic            bcol,
  input logic            seq_active
);

  assert_busy_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata[0] && busy && !seq_active) |=> !ctl_q[0]);

  assert_no_dual_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(sda_oe && scl_oe));

  assert_req_clear_at_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !ctl_q[0]);

  assert_start_from_pins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_det) |-> ($past(scl_in) && !$past(sda_in)));

  assert_buf_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr && seq_active) |=> ($stable(buf_q) && wcol));

  assert_ctl_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && seq_active) |=> $stable(ctl_q[CTLW-1:1]));

  assert_release_on_bcol_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bcol) |-> (!sda_oe && !scl_oe && !ctl_q[0]));

endmodule

bind rs_restart rs_restart_chk #(.BW(BW), .CTLW(CTLW)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .busy(busy), .ctl_wr(ctl_wr),
  .ctl_wdata(ctl_wdata), .ctl_q(ctl_q), .buf_wr(buf_wr), .buf_q(buf_q),
  .sda_in(sda_in), .scl_in(scl_in), .sda_oe(sda_oe), .scl_oe(scl_oe),
  .start_det(start_det), .irq(irq), .wcol(wcol), .bcol(bcol),
  .seq_active(seq_active)
);

// File: tb/sim_rs_restart.sv
module sim_rs_restart;

  localparam int CLK_PERIOD = 10;
  localparam int MAXR = 7;

  logic       clk, rst_n, busy, ctl_wr, buf_wr;
  logic [4:0] ctl_wdata, ctl_q;
  logic [7:0] buf_wdata, buf_q;
  logic [6:0] reload;
  logic       sda_in, scl_in, sda_oe, scl_oe;
  logic       start_det, irq, wcol, bcol;
  logic       ext_sda_low, ext_scl_low;
  logic [3:0] hi;
  int         n_chk, n_fail, n;
  bit         ended;

  assign sda_in = ~(sda_oe | ext_sda_low);
  assign scl_in = ~(scl_oe | ext_scl_low);

  rs_restart u0 (
    .clk(clk), .rst_n(rst_n), .busy(busy), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .ctl_q(ctl_q), .buf_wr(buf_wr),
    .buf_wdata(buf_wdata), .buf_q(buf_q), .reload(reload),
    .sda_in(sda_in), .scl_in(scl_in), .sda_oe(sda_oe), .scl_oe(scl_oe),
    .start_det(start_det), .irq(irq), .wcol(wcol), .bcol(bcol)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic probe(input int sel);
    case (sel)
      0:       return scl_oe;
      1:       return sda_oe;
      2:       return irq;
      default: return start_det;
    endcase
  endfunction

  task automatic cycles_until(input int sel, input logic val, output int cnt);
    cnt = 0;
    while (probe(sel) !== val && cnt < 1000) begin
      @(negedge clk);
      cnt++;
    end
  endtask

  task automatic start_seq(input int r);
    @(negedge clk);
    reload    = 7'(r);
    ctl_wr    = 1'b1;
    ctl_wdata = {hi, 1'b1};
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0; ended = 1'b0; hi = 4'b0000;
    rst_n = 1'b0; busy = 1'b0; ctl_wr = 1'b0; buf_wr = 1'b0;
    ctl_wdata = '0; buf_wdata = '0; reload = '0;
    ext_sda_low = 1'b0; ext_scl_low = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R12: reset state
    chk("R12 reset outs", {sda_oe, scl_oe, start_det, irq, wcol, bcol}, 0);
    chk("R12 reset ctl", ctl_q, 0);
    chk("R12 reset buf", buf_q, 0);

    // R1: request while busy is ignored
    busy = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = 5'b00001;
    @(negedge clk);
    ctl_wr = 1'b0;
    chk("R1 req bit", ctl_q[0], 0);
    repeat (5) @(negedge clk);
    chk("R1 scl idle", scl_oe, 0);
    busy = 1'b0;

    // R2..R6: sweep of reload values
    for (int r = 0; r <= MAXR; r++) begin
      start_seq(r);
      chk("R2 req set", ctl_q[0], 1);
      chk("R2 scl not yet", scl_oe, 0);
      cycles_until(0, 1'b1, n);
      chk("R2 scl delay", n, 1);
      chk("R2 sda released", sda_oe, 0);
      chk("R12 flags cleared", {start_det, irq}, 0);
      cycles_until(0, 1'b0, n);
      chk("R3 scl low len", n, r + 2);
      cycles_until(1, 1'b1, n);
      chk("R4 both high len", n, r + 2);
      chk("R4 scl released", scl_oe, 0);
      cycles_until(3, 1'b1, n);
      chk("R6 start delay", n, 1);
      cycles_until(2, 1'b1, n);
      chk("R5 sda low len", n, r);
      chk("R5 req cleared", ctl_q[0], 0);
      repeat (3) @(negedge clk);
      chk("R5 sda held", sda_oe, 1);
    end

    // R7, R8: writes during a sequence
    start_seq(4);
    cycles_until(0, 1'b1, n);
    buf_wr = 1'b1; buf_wdata = 8'hA5;
    ctl_wr = 1'b1; ctl_wdata = 5'b11110;
    @(negedge clk);
    buf_wr = 1'b0; ctl_wr = 1'b0;
    chk("R7 wcol set", wcol, 1);
    chk("R7 buf kept", buf_q, 0);
    chk("R8 ctl kept", ctl_q[4:1], 0);
    cycles_until(2, 1'b1, n);
    chk("R5 irq done", irq, 1);
    buf_wr = 1'b1; buf_wdata = 8'h3C;
    @(negedge clk);
    buf_wr = 1'b0;
    chk("R7 idle buf write", buf_q, 8'h3C);
    ctl_wr = 1'b1; ctl_wdata = 5'b10100;
    @(negedge clk);
    ctl_wr = 1'b0; hi = 4'b1010;
    chk("R8 idle ctl write", ctl_q, 5'b10100);
    repeat (3) @(negedge clk);
    chk("R8 no request", scl_oe, 0);

    // R12: accept clears sticky write collision
    start_seq(2);
    cycles_until(0, 1'b1, n);
    chk("R12 wcol cleared", wcol, 0);
    chk("R12 irq cleared", irq, 0);
    cycles_until(2, 1'b1, n);
    chk("R8 bits survive", ctl_q, 5'b10100);

    // R3: SDA held low stretches the SCL-low phase
    start_seq(2);
    cycles_until(0, 1'b1, n);
    ext_sda_low = 1'b1;
    repeat (10) @(negedge clk);
    chk("R3 scl stretched", scl_oe, 1);
    ext_sda_low = 1'b0;
    cycles_until(0, 1'b0, n);
    chk("R3 release after sda", n, 1);
    cycles_until(2, 1'b1, n);
    chk("R3 completes", irq, 1);

    // R9, R11: SDA low when SCL rises
    start_seq(3);
    cycles_until(0, 1'b1, n);
    cycles_until(0, 1'b0, n);
    ext_sda_low = 1'b1;
    @(negedge clk);
    chk("R9 bcol", bcol, 1);
    chk("R11 lines released", {sda_oe, scl_oe}, 0);
    chk("R11 req cleared", ctl_q[0], 0);
    chk("R9 no irq", irq, 0);
    ext_sda_low = 1'b0;
    repeat (3) @(negedge clk);

    // R10, R11: SCL pulled low during both-high phase
    start_seq(5);
    cycles_until(0, 1'b1, n);
    chk("R12 bcol cleared", bcol, 0);
    cycles_until(0, 1'b0, n);
    @(negedge clk);
    ext_scl_low = 1'b1;
    @(negedge clk);
    chk("R10 bcol", bcol, 1);
    chk("R11 lines released", {sda_oe, scl_oe}, 0);
    chk("R11 req cleared", ctl_q[0], 0);
    ext_scl_low = 1'b0;
    repeat (5) @(negedge clk);
    chk("R11 stays idle", {sda_oe, scl_oe}, 0);

    finish_run();
  end

endmodule